// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block gathers five interrupt sources into two request lines, one for a high-priority vector and one for a low-priority vector. Three sources are external pins with a selectable active edge. The fourth is the overflow of a free-running counter that can be 8 or 16 bits wide. The fifth is a detector that flags any change on the upper half of an 8-bit input port. Each source has a sticky flag that hardware sets and software clears. Each source also has an enable. Every source except external pin 0 has a priority bit that sends it to the high or the low level. External pin 0 is always high priority.

A source is pending when both its flag and its enable are set. Any pending source raises the wake output, whatever the global enable says. The two request outputs follow only while the global enable is on. When a high-level and a low-level source are pending in the same cycle, the high request wins and the low request is held off. The configuration inputs (enables, priorities, edge selects, counter width, global enable) are sampled live every cycle. Flags are cleared by one-cycle pulses on a clear vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every flag, `wake`, `req_hi`, `req_lo` and `tmr_count` are zero.
- R2: Pins pass through a two-stage synchronizer, so a pin edge sets its flag on the third rising clock edge after the pin changes. The bit order is `flags[0..2]` for `ext_pin[0..2]`. `ext_rise[i]`=1 selects the rising edge and 0 selects the falling edge. An edge of the other direction leaves the flag unchanged.
- R3: A flag stays set until a `flag_clr` pulse on its bit clears it. If a set event and a clear pulse arrive on the same clock edge, the flag ends up set.
- R4: `tmr_wide`=0 selects 8-bit mode. In this mode each clock with `tmr_tick`=1 increments `tmr_count[7:0]` and leaves `tmr_count[15:8]` unchanged. The step from 0xFF to 0x00 sets `flags[3]` on the same edge.
- R5: `tmr_wide`=1 selects 16-bit mode. The whole count increments, and only the step from 0xFFFF to 0x0000 sets `flags[3]`. The step from 0x00FF to 0x0100 does not set it.
- R6: A change on any of `port_in[7:4]` sets `flags[4]` on the third clock edge after the change. Changes on `port_in[3:0]` have no effect.
- R7: A pending source 0 always counts as high level, and `src_hi[0]` is ignored.
- R8: Sources 1 to 4 are routed by their `src_hi` bit: 1 sends the source to the high level and 0 to the low level. A source is pending only when both its flag and its `src_en` bit are 1.
- R9: `wake` is 1 exactly when at least one source is pending, independent of `gie`.
- R10: `req_hi` is `gie` AND (some high-level source is pending). `req_lo` is `gie` AND (some low-level source is pending) AND NOT (any high-level source pending). The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 3 | External interrupt pins |
| ext_rise | input | 3 | Per-pin edge select, 1 = rising |
| port_in | input | 8 | Port watched for changes on bits 7:4 |
| tmr_tick | input | 1 | Counter increment enable |
| tmr_wide | input | 1 | Counter width, 1 = 16-bit |
| src_en | input | 5 | Per-source enable |
| src_hi | input | 5 | Per-source priority, 1 = high (bit 0 ignored) |
| gie | input | 1 | Global request enable |
| flag_clr | input | 5 | One-cycle flag clear pulses |
| flags | output | 5 | Sticky source flags |
| tmr_count | output | 16 | Counter value |
| wake | output | 1 | Any source pending |
| req_hi | output | 1 | High-level vector request |
| req_lo | output | 1 | Low-level vector request |

## Verification
The assertions assume that `ext_pin` and `port_in` sit at zero while reset is asserted. The synchronizers reset to zero, so a high level on a pin at reset release would look like an edge. The bench holds every pin and port bit low through reset and changes them only at falling clock edges. The flag-hold property also assumes that nothing else sets a flag while a clear pulse is absent. The bench keeps `flag_clr` at zero except for single-cycle clears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC      = 5;
  localparam int NEXT      = 3;
  localparam int TMR_W     = 16;
  localparam int HALF_W    = TMR_W / 2;
  localparam int SRC_TMR   = 3;
  localparam int SRC_CHG   = 4;

  // counter step: returns {wrapped, next_value}
  function automatic logic [TMR_W:0] tmr_step(input logic [TMR_W-1:0] cur,
                                               input logic wide);
    logic [TMR_W-1:0] nxt;
    logic             wrap;
    if (wide) begin
      nxt  = cur + 1'b1;
      wrap = (cur == {TMR_W{1'b1}});
    end else begin
      nxt  = {cur[TMR_W-1:HALF_W], cur[HALF_W-1:0] + 1'b1};
      wrap = (cur[HALF_W-1:0] == {HALF_W{1'b1}});
    end
    return {wrap, nxt};
  endfunction

  // split pending sources into high and low level sets
  function automatic logic [2*NSRC-1:0] route(input logic [NSRC-1:0] pend,
                                              input logic [NSRC-1:0] hi_sel);
    logic [NSRC-1:0] hi_eff;
    hi_eff = {hi_sel[NSRC-1:1], 1'b1};
    return {pend & hi_eff, pend & ~hi_eff};
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int N        = 3,
  parameter int STAGES   = 2,
  parameter bit ANY_EDGE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  input  logic [N-1:0] rise_sel,
  output logic [N-1:0] hit
);
  logic [N-1:0] sync_q [STAGES];
  logic [N-1:0] prev_q;
  logic [N-1:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= din;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign cur = sync_q[STAGES-1];

  generate
    if (ANY_EDGE) begin : g_any
      logic [N-1:0] unused_sel;
      assign unused_sel = rise_sel;
      assign hit = cur ^ prev_q;
    end else begin : g_pol
      for (genvar i = 0; i < N; i++) begin : g_bit
        assign hit[i] = rise_sel[i] ? (cur[i] & ~prev_q[i]) : (~cur[i] & prev_q[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_tmr.sv
module irq_tmr
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wide,
  output logic [TMR_W-1:0] count,
  output logic             wrap
);
  logic [TMR_W:0] step;

  assign step = tmr_step(count, wide);
  assign wrap = tick & step[TMR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= step[TMR_W-1:0];
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic [NEXT-1:0]  ext_rise,
  input  logic [7:0]       port_in,
  input  logic             tmr_tick,
  input  logic             tmr_wide,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_hi,
  input  logic             gie,
  input  logic [NSRC-1:0]  flag_clr,
  output logic [NSRC-1:0]  flags,
  output logic [TMR_W-1:0] tmr_count,
  output logic             wake,
  output logic             req_hi,
  output logic             req_lo
);
  logic [NEXT-1:0]     ext_hit;
  logic [3:0]          chg_hit;
  logic                tmr_wrap;
  logic [NSRC-1:0]     set_vec;
  logic [NSRC-1:0]     pend;
  logic [NSRC-1:0]     pend_hi;
  logic [NSRC-1:0]     pend_lo;
  logic                unused_bits;

  assign unused_bits = ^{port_in[3:0], src_hi[0]};

  irq_edge_sync #(.N(NEXT), .STAGES(SYNC_STAGES), .ANY_EDGE(1'b0)) u_ext (
    .clk(clk), .rst_n(rst_n), .din(ext_pin), .rise_sel(ext_rise), .hit(ext_hit)
  );

  irq_edge_sync #(.N(4), .STAGES(SYNC_STAGES), .ANY_EDGE(1'b1)) u_chg (
    .clk(clk), .rst_n(rst_n), .din(port_in[7:4]), .rise_sel(4'b0), .hit(chg_hit)
  );

  irq_tmr u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .wide(tmr_wide),
    .count(tmr_count), .wrap(tmr_wrap)
  );

  assign set_vec = {|chg_hit, tmr_wrap, ext_hit};

  irq_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set_vec), .clr(flag_clr), .flags(flags)
  );

  assign pend               = flags & src_en;
  assign {pend_hi, pend_lo} = route(pend, {src_hi[NSRC-1:1], 1'b0});

  assign wake   = |pend;
  assign req_hi = gie & (|pend_hi);
  assign req_lo = gie & (|pend_lo) & ~(|pend_hi);
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             gie,
  input logic             tmr_wide,
  input logic [NSRC-1:0]  src_en,
  input logic [NSRC-1:0]  flag_clr,
  input logic [NSRC-1:0]  flags,
  input logic [TMR_W-1:0] tmr_count,
  input logic             tmr_wrap,
  input logic             wake,
  input logic             req_hi,
  input logic             req_lo
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (flags == '0) || !rst_n);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_hold
      assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[i] && !flag_clr[i]) |=> flags[i]);
    end
  endgenerate

  assert_tmr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> flags[SRC_TMR]);

  assert_narrow_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_wide |=> $stable(tmr_count[TMR_W-1:HALF_W]));

  assert_src0_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && flags[0] && src_en[0]) |-> req_hi);

  assert_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hi || req_lo) |-> wake);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_hi && req_lo));

  assert_gie_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!req_hi && !req_lo));
endmodule

bind irq_prio_ctrl irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .tmr_wide(tmr_wide), .src_en(src_en),
  .flag_clr(flag_clr), .flags(flags), .tmr_count(tmr_count), .tmr_wrap(tmr_wrap),
  .wake(wake), .req_hi(req_hi), .req_lo(req_lo)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_pin = '0;
  logic [2:0]  ext_rise = '1;
  logic [7:0]  port_in = '0;
  logic        tmr_tick = 1'b0;
  logic        tmr_wide = 1'b0;
  logic [4:0]  src_en = '0;
  logic [4:0]  src_hi = '1;
  logic        gie = 1'b0;
  logic [4:0]  flag_clr = '0;
  logic [4:0]  flags;
  logic [15:0] tmr_count;
  logic        wake, req_hi, req_lo;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise(ext_rise),
    .port_in(port_in), .tmr_tick(tmr_tick), .tmr_wide(tmr_wide),
    .src_en(src_en), .src_hi(src_hi), .gie(gie), .flag_clr(flag_clr),
    .flags(flags), .tmr_count(tmr_count), .wake(wake),
    .req_hi(req_hi), .req_lo(req_lo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags(input logic [4:0] m);
    flag_clr = m;
    cyc(1);
    flag_clr = '0;
  endtask

  task automatic ticks(input int n);
    tmr_tick = 1'b1;
    cyc(n);
    tmr_tick = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 flags", flags, 0);
    chk("R1 outs", {wake, req_hi, req_lo}, 0);
    chk("R1 count", tmr_count, 0);

    // R2 edge polarity on each pin
    for (int i = 0; i < 3; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        ext_rise[i] = pol[0];
        cyc(4);
        clear_flags(5'b1 << i);
        ext_pin[i] = ~pol[0];
        cyc(4);
        chk("R2 wrong edge", flags[i], 0);
        ext_pin[i] = pol[0];
        cyc(2);
        chk("R2 before latency", flags[i], 0);
        cyc(1);
        chk("R2 edge sets", flags[i], 1);
      end
    end

    // R3 hold, clear, set-wins
    cyc(5);
    chk("R3 hold", flags[2:0], 3'b111);
    clear_flags(5'b00001);
    chk("R3 clear", flags[2:0], 3'b110);
    ext_rise[0] = 1'b0;
    ext_pin[0] = 1'b0;
    cyc(2);
    flag_clr = 5'b00001;
    cyc(1);
    flag_clr = '0;
    chk("R3 set wins", flags[0], 1);

    // R6 port change: low nibble ignored, each upper bit sets
    clear_flags(5'h1f);
    for (int b = 0; b < 4; b++) begin
      port_in[b] = ~port_in[b];
      cyc(4);
      chk("R6 low nibble ignored", flags[4], 0);
    end
    for (int b = 4; b < 8; b++) begin
      port_in[b] = ~port_in[b];
      cyc(3);
      chk("R6 upper bit change", flags[4], 1);
      clear_flags(5'h10);
      cyc(2);
      chk("R6 cleared", flags[4], 0);
    end

    // R4 8-bit counter
    tmr_wide = 1'b0;
    ticks(255);
    chk("R4 count ff", tmr_count, 16'h00ff);
    chk("R4 no flag yet", flags[3], 0);
    ticks(1);
    chk("R4 wrap count", tmr_count, 16'h0000);
    chk("R4 wrap flag", flags[3], 1);
    clear_flags(5'h08);

    // R5 16-bit counter
    tmr_wide = 1'b1;
    ticks(256);
    chk("R5 byte carry", tmr_count, 16'h0100);
    chk("R5 no flag on byte carry", flags[3], 0);
    tmr_wide = 1'b0;
    ticks(300);
    chk("R4 high byte held", tmr_count, {8'h01, 8'(300)});
    clear_flags(5'h08);
    tmr_wide = 1'b1;
    ticks(32'h10000 - 32'h0100 - 32'd44 - 32'd1);
    chk("R5 count ffff", tmr_count, 16'hffff);
    chk("R5 no flag yet", flags[3], 0);
    ticks(1);
    chk("R5 wrap count", tmr_count, 16'h0000);
    chk("R5 wrap flag", flags[3], 1);

    // set all flags for the routing sweep
    ext_rise = 3'b111;
    ext_pin = 3'b000;
    cyc(4);
    ext_pin = 3'b111;
    port_in[7] = ~port_in[7];
    cyc(4);
    chk("all flags set", flags, 5'h1f);

    // R7 R8 R9 R10 exhaustive sweep over enable, priority, gie
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 32; e++) begin
        for (int p = 0; p < 32; p++) begin
          int nh, nl;
          logic exp_hi, exp_lo, exp_wake;
          gie = g[0];
          src_en = e[4:0];
          src_hi = p[4:0];
          #1;
          nh = 0;
          nl = 0;
          for (int s = 0; s < 5; s++) begin
            if (e[s]) begin
              if (s == 0 || p[s]) nh++;
              else nl++;
            end
          end
          exp_wake = (nh + nl) > 0;
          exp_hi = g[0] && nh > 0;
          exp_lo = g[0] && nl > 0 && nh == 0;
          chk("R9 wake", wake, exp_wake);
          if (e[0]) chk("R7 src0 high", req_hi, g[0]);
          chk("R8 R10 req_hi", req_hi, exp_hi);
          chk("R8 R10 req_lo", req_lo, exp_lo);
          cyc(1);
        end
      end
    end

    // R8 disabled flags never pend
    src_en = '0;
    gie = 1'b1;
    #1;
    chk("R8 none enabled", {wake, req_hi, req_lo}, 0);
    report();
  end
endmodule